// File: doc/BRIEF.md
# Indirect Configuration Access Window

This block turns configuration requests into register accesses on the controller's internal bus. Each request is addressed by bus, device, function and register offset, and it reads or writes 1, 2 or 4 bytes. Requests to the root port (bus 0, device 0, function 0) go directly to the root port's local configuration space at controller offset `reg`. Every other function can only be reached through a single 4 KiB data window. The block therefore first writes a function-select register and then makes the data access through the window.

Before any bus traffic the block checks the request. A rejected request produces no downstream access, and its completion is still signalled. Byte lanes follow little-endian order: write data is placed on the lanes selected by `reg[1:0]`, and read data is returned right-aligned. Only one request is in flight at a time. The select write and the data access cannot be separated by another request.

Top module: `cfg_window`

## Requirements
- R1: A valid request to bus 0, device 0, function 0 makes exactly one downstream access, at word address `{reg[11:2],2'b00}`, with no select write before it.
- R2: A valid request to any other function makes two downstream accesses in this order. The first is a full-word write of `bus<<20 | dev<<15 | func<<12` to address 0x9000. The second is the data access at 0x8000 + `{reg[11:2],2'b00}`.
- R3: On bus 0, a request with a nonzero device or function is rejected.
- R4: A bus number outside BUS_LO..BUS_HI is rejected. The defaults are 0..31.
- R5: A device above 31, a function above 7 or a register above 0xFFF is rejected.
- R6: A rejected request makes no downstream access. It completes with `rsp_done`, and `rsp_rdata` is all ones for a read and zero for a write.
- R7: A size other than 1, 2 or 4 is rejected. So is a 2-byte request with `reg[0]`=1, and a 4-byte request with `reg[1:0]`≠0.
- R8: Byte enable bit k maps to data bits 8k+7..8k. The enables are the lowest `size` bits shifted left by `reg[1:0]`. Write data keeps the low `size` bytes of `req_wdata`, shifted left by 8·`reg[1:0]`, with the other lanes zero. The select write uses enables 4'hF.
- R9: Read data is the downstream word shifted right by 8·`reg[1:0]`, with bytes above `size` cleared. A successful write returns zero.
- R10: A request is accepted on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` then stays low until the cycle after the one-cycle `rsp_done` pulse.
- R11: A downstream access keeps `ctl_valid`, `ctl_write`, `ctl_addr`, `ctl_wdata` and `ctl_be` unchanged until the cycle in which `ctl_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_bus | input | BUS_W | Bus number |
| req_dev | input | DEV_W | Device number |
| req_fn | input | FN_W | Function number |
| req_reg | input | REG_W | Register byte offset |
| req_size | input | 3 | Access size in bytes |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read result, right-aligned |
| ctl_valid | output | 1 | Downstream access request |
| ctl_write | output | 1 | Downstream access is a write |
| ctl_addr | output | ADDR_W | Downstream byte address, word-aligned |
| ctl_wdata | output | 32 | Downstream write data on byte lanes |
| ctl_be | output | 4 | Downstream byte enables |
| ctl_ack | input | 1 | Downstream access complete |
| ctl_rdata | input | 32 | Downstream read word, valid with ctl_ack |

## Verification
The hardest case to reach is a second request that is already waiting while the select-then-data sequence of the first is still running. It must not slip in between the two accesses, and it must be taken only after the completion pulse. The bench presents a new request in the cycle right after an acceptance and holds it there. It then checks that the downstream log holds the first request's select write and data access back to back, and that the second request is taken only afterwards. The downstream model's acknowledge latency is varied, so both accesses of a sequence are seen held for several cycles.

// File: rtl/cfg_window.sv
module cfg_window #(
  parameter int BUS_W = 8,
  parameter int DEV_W = 8,
  parameter int FN_W = 4,
  parameter int REG_W = 16,
  parameter int ADDR_W = 16,
  parameter logic [BUS_W-1:0] BUS_LO = '0,
  parameter logic [BUS_W-1:0] BUS_HI = BUS_W'(31),
  parameter logic [ADDR_W-1:0] SEL_OFS = ADDR_W'(16'h9000),
  parameter logic [ADDR_W-1:0] WIN_OFS = ADDR_W'(16'h8000)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BUS_W-1:0]  req_bus,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [FN_W-1:0]   req_fn,
  input  logic [REG_W-1:0]  req_reg,
  input  logic [2:0]        req_size,
  input  logic              req_wr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_done,
  output logic [31:0]       rsp_rdata,
  output logic              ctl_valid,
  output logic              ctl_write,
  output logic [ADDR_W-1:0] ctl_addr,
  output logic [31:0]       ctl_wdata,
  output logic [3:0]        ctl_be,
  input  logic              ctl_ack,
  input  logic [31:0]       ctl_rdata
);

  localparam logic [BUS_W-1:0] BUS_SPAN = BUS_HI - BUS_LO;
  localparam logic [DEV_W-1:0] DEV_MAX = DEV_W'(31);
  localparam logic [FN_W-1:0]  FN_MAX = FN_W'(7);
  localparam logic [REG_W-1:0] REG_MAX = REG_W'(12'hFFF);

  typedef enum logic [1:0] {S_IDLE, S_SEL, S_ACC, S_FIN} st_t;

  st_t st_q;
  logic [31:0] sel_q, wdata_q, mask_q, rdata_q;
  logic [ADDR_W-1:0] addr_q;
  logic [3:0] be_q;
  logic [1:0] off_q;
  logic wr_q;

  logic [BUS_W-1:0] bus_rel;
  logic in_range, is_root, bus0_bad, size_ok, align_ok, fields_ok, req_ok;
  logic [1:0] off;
  logic [3:0] be;
  logic [31:0] mask, lane_wdata, sel_val;
  logic [ADDR_W-1:0] word_addr;

  assign bus_rel   = req_bus - BUS_LO;
  assign in_range  = bus_rel <= BUS_SPAN;
  assign is_root   = req_bus == '0 && req_dev == '0 && req_fn == '0;
  assign bus0_bad  = req_bus == '0 && !is_root;
  assign fields_ok = req_dev <= DEV_MAX && req_fn <= FN_MAX && req_reg <= REG_MAX;
  assign size_ok   = req_size == 3'd1 || req_size == 3'd2 || req_size == 3'd4;
  assign off       = req_reg[1:0];
  assign align_ok  = (req_size == 3'd4) ? (off == 2'd0) :
                     (req_size == 3'd2) ? !off[0] : 1'b1;
  assign req_ok    = in_range && fields_ok && !bus0_bad && size_ok && align_ok;

  always_comb begin
    case (req_size)
      3'd1:    begin be = 4'b0001 << off; mask = 32'h0000_00FF; end
      3'd2:    begin be = 4'b0011 << off; mask = 32'h0000_FFFF; end
      default: begin be = 4'b1111;        mask = 32'hFFFF_FFFF; end
    endcase
  end

  assign lane_wdata = (req_wdata & mask) << {off, 3'b000};
  assign sel_val    = (32'(req_bus) << 20) | (32'(req_dev[4:0]) << 15) |
                      (32'(req_fn[2:0]) << 12);
  assign word_addr  = ADDR_W'({req_reg[11:2], 2'b00}) + (is_root ? '0 : WIN_OFS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      sel_q   <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
      rdata_q <= '0;
      addr_q  <= '0;
      be_q    <= '0;
      off_q   <= '0;
      wr_q    <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (req_valid) begin
          sel_q   <= sel_val;
          wdata_q <= lane_wdata;
          mask_q  <= mask;
          addr_q  <= word_addr;
          be_q    <= be;
          off_q   <= off;
          wr_q    <= req_wr;
          if (!req_ok) begin
            rdata_q <= req_wr ? 32'h0 : 32'hFFFF_FFFF;
            st_q    <= S_FIN;
          end else begin
            st_q <= is_root ? S_ACC : S_SEL;
          end
        end
        S_SEL: if (ctl_ack) st_q <= S_ACC;
        S_ACC: if (ctl_ack) begin
          rdata_q <= wr_q ? 32'h0 : ((ctl_rdata >> {off_q, 3'b000}) & mask_q);
          st_q    <= S_FIN;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready = st_q == S_IDLE;
  assign rsp_done  = st_q == S_FIN;
  assign rsp_rdata = rdata_q;
  assign ctl_valid = st_q == S_SEL || st_q == S_ACC;
  assign ctl_write = (st_q == S_SEL) ? 1'b1 : wr_q;
  assign ctl_addr  = (st_q == S_SEL) ? SEL_OFS : addr_q;
  assign ctl_wdata = (st_q == S_SEL) ? sel_q : (wr_q ? wdata_q : 32'h0);
  assign ctl_be    = (st_q == S_SEL) ? 4'hF : be_q;

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid && !ctl_ack |=> ctl_valid && $stable(ctl_addr) && $stable(ctl_wdata)
                              && $stable(ctl_be) && $stable(ctl_write));

  p_sel_then_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid && ctl_ack && ctl_addr == SEL_OFS |=> ctl_valid && ctl_addr != SEL_OFS);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done && req_ready);

  p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  p_lanes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid |-> ($countones(ctl_be) == 1 || $countones(ctl_be) == 2 ||
                   $countones(ctl_be) == 4));

endmodule

// File: tb/test_cfg_window.sv
module test_cfg_window;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic req_valid = 0, req_ready, req_wr = 0, rsp_done, ctl_valid, ctl_write, ctl_ack = 0;
  logic [7:0] req_bus = 0, req_dev = 0;
  logic [3:0] req_fn = 0;
  logic [15:0] req_reg = 0, ctl_addr;
  logic [2:0] req_size = 0;
  logic [31:0] req_wdata = 0, rsp_rdata, ctl_wdata, ctl_rdata = 0;
  logic [3:0] ctl_be;

  cfg_window i_cfg_window (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bus(req_bus), .req_dev(req_dev), .req_fn(req_fn), .req_reg(req_reg),
    .req_size(req_size), .req_wr(req_wr), .req_wdata(req_wdata), .rsp_done(rsp_done),
    .rsp_rdata(rsp_rdata), .ctl_valid(ctl_valid), .ctl_write(ctl_write), .ctl_addr(ctl_addr),
    .ctl_wdata(ctl_wdata), .ctl_be(ctl_be), .ctl_ack(ctl_ack), .ctl_rdata(ctl_rdata));

  int checks = 0, errors = 0;
  logic [31:0] mem [int];
  logic [52:0] txlog[$];
  logic [52:0] exp_q[$];
  logic [31:0] exp_rd;
  int lat = 0, wcnt = 0;

  function automatic logic [31:0] memget(int a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // downstream model: acknowledges after lat wait cycles, logs each access
  always @(posedge clk) begin
    ctl_ack <= 1'b0;
    if (ctl_valid && !ctl_ack) begin
      if (wcnt >= lat) begin
        logic [31:0] w;
        w = memget(int'(ctl_addr));
        ctl_ack <= 1'b1;
        ctl_rdata <= w;
        wcnt <= 0;
        txlog.push_back({ctl_write, ctl_addr, ctl_write ? ctl_wdata : 32'h0, ctl_be});
        if (ctl_write && ctl_addr != 16'h9000) begin
          for (int k = 0; k < 4; k++) if (ctl_be[k]) w[8*k +: 8] = ctl_wdata[8*k +: 8];
          mem[int'(ctl_addr)] = w;
        end
      end else wcnt <= wcnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference expectation, from the requirements
  task automatic calc(input logic [7:0] b, input logic [7:0] d, input logic [3:0] f,
                      input logic [15:0] r, input logic [2:0] sz, input bit wr, input logic [31:0] wd);
    bit ok, root;
    logic [1:0] off;
    logic [31:0] mask, sel;
    logic [3:0] be;
    logic [15:0] a;
    off = r[1:0];
    root = (b == 0 && d == 0 && f == 0);
    ok = (b <= 31) && (d <= 31) && (f <= 7) && (r <= 16'hFFF) && !(b == 0 && !root)
         && (sz == 1 || (sz == 2 && !off[0]) || (sz == 4 && off == 0));
    mask = (sz == 1) ? 32'hFF : (sz == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
    be = (sz == 1) ? (4'b0001 << off) : (sz == 2) ? (4'b0011 << off) : 4'hF;
    a = {4'h0, r[11:2], 2'b00} + (root ? 16'h0 : 16'h8000);
    sel = (32'(b) << 20) | (32'(d) << 15) | (32'(f) << 12);
    exp_q.delete();
    if (ok) begin
      if (!root) exp_q.push_back({1'b1, 16'h9000, sel, 4'hF});
      exp_q.push_back({wr, a, wr ? ((wd & mask) << (8 * off)) : 32'h0, be});
    end
    exp_rd = !ok ? (wr ? 32'h0 : 32'hFFFF_FFFF) :
             wr ? 32'h0 : ((memget(int'(a)) >> (8 * off)) & mask);
  endtask

  task automatic present(input logic [7:0] b, input logic [7:0] d, input logic [3:0] f,
                         input logic [15:0] r, input logic [2:0] sz, input bit wr, input logic [31:0] wd);
    req_bus = b; req_dev = d; req_fn = f; req_reg = r;
    req_size = sz; req_wr = wr; req_wdata = wd; req_valid = 1;
  endtask

  task automatic wait_accept;
    forever begin
      if (req_ready) begin @(posedge clk); break; end
      @(negedge clk);
    end
  endtask

  task automatic check_done(input string tag);
    forever begin
      @(negedge clk);
      if (rsp_done) break;
      chk(req_ready == 0, {tag, " R10 ready low while busy"}, req_ready, 0);
    end
    chk(rsp_rdata == exp_rd, {tag, " rdata"}, rsp_rdata, exp_rd);
    chk(txlog.size() == exp_q.size(), {tag, " access count"}, txlog.size(), exp_q.size());
    foreach (exp_q[i])
      if (i < txlog.size()) chk(txlog[i] == exp_q[i], {tag, " access"}, txlog[i], exp_q[i]);
    txlog.delete();
    @(negedge clk);
    chk(rsp_done == 0 && req_ready == 1, {tag, " R10 done one cycle"}, {rsp_done, req_ready}, 2'b01);
  endtask

  task automatic run(input logic [7:0] b, input logic [7:0] d, input logic [3:0] f,
                     input logic [15:0] r, input logic [2:0] sz, input bit wr,
                     input logic [31:0] wd, input string tag);
    calc(b, d, f, r, sz, wr, wd);
    present(b, d, f, r, sz, wr, wd);
    wait_accept();
    @(negedge clk);
    req_valid = 0;
    if (rsp_done) begin
      chk(rsp_rdata == exp_rd, {tag, " rdata"}, rsp_rdata, exp_rd);
      chk(txlog.size() == exp_q.size(), {tag, " R6 access count"}, txlog.size(), exp_q.size());
      txlog.delete();
      @(negedge clk);
    end else check_done(tag);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    mem[32'h10] = 32'h1122_3344;
    mem[32'h8100] = 32'hA1B2_C3D4;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !rsp_done && !ctl_valid, "R10 reset state", {req_ready, rsp_done, ctl_valid}, 3'b100);

    run(0, 0, 0, 16'h10, 4, 0, 0, "R1 root read");
    lat = 3;
    run(0, 0, 0, 16'h12, 2, 0, 0, "R9 root 2B read upper");
    run(0, 0, 0, 16'h3E, 2, 1, 32'hDEAD_BEEF, "R8 root 2B write");
    run(0, 0, 0, 16'h3C, 4, 0, 0, "R1 root readback");
    lat = 0;
    run(1, 3, 2, 16'h100, 4, 0, 0, "R2 downstream read");
    lat = 2;
    run(5, 31, 7, 16'hFFC, 4, 1, 32'h0BAD_F00D, "R2 downstream write max fields");
    run(1, 3, 2, 16'h103, 1, 1, 32'h0000_0077, "R8 1B write lane3");
    run(1, 3, 2, 16'h102, 2, 0, 0, "R9 2B read");
    for (int o = 0; o < 4; o++) begin
      lat = o;
      run(2, 0, 1, 16'h200 + 16'(o), 1, 1, 32'hFFFF_FF00 | 32'(o + 8'h40), "R8 byte lane write");
      run(2, 0, 1, 16'h200 + 16'(o), 1, 0, 0, "R9 byte lane read");
    end
    run(2, 0, 1, 16'h200, 4, 0, 0, "R9 assembled word");

    run(0, 1, 0, 16'h0, 4, 0, 0, "R3 bus0 dev1 read");
    run(0, 0, 1, 16'h0, 4, 1, 32'h1, "R3 bus0 fn1 write");
    run(32, 0, 0, 16'h0, 4, 0, 0, "R4 bus above range");
    run(200, 1, 0, 16'h0, 4, 1, 32'h5, "R4 bus far above");
    run(1, 32, 0, 16'h0, 4, 0, 0, "R5 dev 32");
    run(1, 0, 8, 16'h0, 4, 0, 0, "R5 fn 8");
    run(1, 0, 0, 16'h1000, 4, 0, 0, "R5 reg 0x1000");
    run(1, 0, 0, 16'h0, 3, 0, 0, "R7 size 3");
    run(1, 0, 0, 16'h0, 0, 1, 32'h9, "R7 size 0 write");
    run(1, 0, 0, 16'h2, 4, 0, 0, "R7 misaligned 4B");
    run(0, 0, 0, 16'h11, 2, 0, 0, "R7 misaligned 2B root");
    run(0, 0, 0, 16'h10, 4, 0, 0, "R6 root unchanged after rejects");
    run(2, 0, 0, 16'h0, 4, 0, 0, "R11 read fn 0 on bus 2");

    // R10: second request waits behind a select/data sequence
    lat = 2;
    calc(1, 3, 2, 16'h100, 4, 0, 0);
    present(1, 3, 2, 16'h100, 4, 0, 0);
    wait_accept();
    @(negedge clk);
    present(0, 0, 0, 16'h10, 1, 0, 0);
    check_done("R10 first of pair");
    calc(0, 0, 0, 16'h10, 1, 0, 0);
    wait_accept();
    @(negedge clk);
    req_valid = 0;
    check_done("R10 second of pair");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule